// File: doc/BRIEF.md
# Receive Ring Writer

The block takes received Ethernet frames as a byte stream and stores them in a circular buffer made of 256-byte pages in local packet memory. A start page and a stop page bound the ring. A boundary page marks how far the host has consumed. A current page marks where the next frame will land. When a frame begins, the block decides from these pointers whether a maximum-size frame still fits. If not, or if the receiver is halted, it discards the whole frame and emits a one-cycle drop pulse.

An accepted frame is written one byte per cycle through a byte-write port. The data starts four bytes into the current page, and bytes that pass the stop page continue at the start page. After the last byte, the block fills the four reserved bytes with a link header: status, next page, and stored length. It then moves the current page to the next free page and raises a receive-done interrupt flag. The host reads frames back by following the next-page links.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset, `cur_pg` is 0, `rx_irq` is 0, `rx_stat` is 0, `rx_drop` is 0 and `mem_we` is 0.
- R2: Byte address = page × 256 + offset. The first data byte of an accepted frame is written at `cur_pg`×256+4, and each later byte at the next address.
- R3: A frame is dropped when `cfg_stop_pg` is not greater than `cfg_start_pg`.
- R4: Free space in bytes is (bnd−cur)×256 when cur < bnd. Otherwise it is (stop−start)×256 − (cur−bnd)×256. The frame is dropped when this is below 1518 (1514+4).
- R5: A frame is dropped when `cmd_halt` is high at its first byte.
- R6: For a dropped frame, `rx_drop` pulses for one cycle, the rest of the frame up to its end marker is ignored, and no memory write, pointer change, `rx_stat` change or `rx_irq` change occurs.
- R7: With L the frame length, next page = cur + ceil((L+8)/256). If that is ≥ stop, (stop−start) is subtracted.
- R8: The header occupies `cur_pg`×256 + 0..3 and holds, in order: 0x01 (good frame), next page, (L+4) low byte, (L+4) high byte.
- R9: A data byte whose address would equal stop×256 is written at start×256 instead, and writing continues from there.
- R10: When the header is complete, `cur_pg` takes the next page, `rx_irq` is set and `rx_stat` becomes 0x01. `irq_clr` clears `rx_irq`, but a set in the same cycle wins.
- R11: `cur_ld` loads `cur_ld_pg` into `cur_pg` when no frame is in progress.
- R12: The header is written over the four cycles after the end byte, and `cur_pg` changes with the fourth header write. A new frame may start no sooner than the fifth cycle after the end byte.
- R13: Every memory write address lies in [start×256, stop×256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_pg | input | 8 | First page of the ring |
| cfg_stop_pg | input | 8 | Page one past the end of the ring |
| cfg_bnd_pg | input | 8 | Host consumption boundary page |
| cmd_halt | input | 1 | Receiver halted; new frames are dropped |
| cur_ld | input | 1 | Load the current-page pointer |
| cur_ld_pg | input | 8 | Value for the current-page load |
| irq_clr | input | 1 | Clear the receive-done flag |
| frm_sof | input | 1 | First byte of a frame (with frm_valid) |
| frm_valid | input | 1 | Frame byte valid |
| frm_eof | input | 1 | Last byte of a frame (with frm_valid) |
| frm_data | input | 8 | Frame byte |
| mem_we | output | 1 | Packet memory byte write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write byte |
| cur_pg | output | 8 | Current-page pointer |
| rx_stat | output | 8 | Receive status of the last stored frame |
| rx_irq | output | 1 | Receive-done flag |
| rx_drop | output | 1 | One-cycle pulse for a discarded frame |

## Verification
Some properties are checked on every cycle by the assertions. Writes never leave the ring, and a drop pulse never coincides with a write. A new frame only begins while the writer is idle. Any move of the current page not caused by a load is accompanied by the receive-done flag and good status.

Other behaviour can only be shown by the directed scenarios:
- the free-space threshold on either side of 1518 bytes;
- the page rounding at exactly one full page;
- data wrapping past the stop page;
- header byte values;
- the four-cycle header latency;
- the three drop causes.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_SKIP, ST_HDR} rxr_state_e;
  localparam int HDR_BYTES = 4;
  localparam int CRC_PAD   = 4;
  localparam logic [7:0] RX_GOOD = 8'h01;
endpackage

// File: rtl/rxr_space_chk.sv
`timescale 1ns/1ps
module rxr_space_chk #(
  parameter int PG_W      = 8,
  parameter int OFF_W     = 8,
  parameter int MAX_FRAME = 1514
) (
  input  logic [PG_W-1:0] start_pg,
  input  logic [PG_W-1:0] stop_pg,
  input  logic [PG_W-1:0] bnd_pg,
  input  logic [PG_W-1:0] cur_pg,
  output logic            room_ok
);
  localparam int AW   = PG_W + OFF_W;
  localparam int NEED = MAX_FRAME + rxr_pkg::HDR_BYTES;
  localparam logic [AW:0] NEED_B = (AW+1)'(NEED);

  logic [AW:0] ring_b, cur_b, bnd_b, gap_b, avail_b;

  always_comb begin
    ring_b  = {1'b0, stop_pg, {OFF_W{1'b0}}} - {1'b0, start_pg, {OFF_W{1'b0}}};
    cur_b   = {1'b0, cur_pg, {OFF_W{1'b0}}};
    bnd_b   = {1'b0, bnd_pg, {OFF_W{1'b0}}};
    gap_b   = '0;
    avail_b = '0;
    room_ok = 1'b0;
    if (stop_pg > start_pg) begin
      if (cur_pg < bnd_pg) begin
        avail_b = bnd_b - cur_b;
        room_ok = (avail_b >= NEED_B);
      end else begin
        gap_b = cur_b - bnd_b;
        if (gap_b <= ring_b) begin
          avail_b = ring_b - gap_b;
          room_ok = (avail_b >= NEED_B);
        end
      end
    end
  end
endmodule

// File: rtl/rxr_next_page.sv
`timescale 1ns/1ps
module rxr_next_page #(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8,
  parameter int LEN_W = 16
) (
  input  logic [PG_W-1:0]  cur_pg,
  input  logic [PG_W-1:0]  start_pg,
  input  logic [PG_W-1:0]  stop_pg,
  input  logic [LEN_W-1:0] frm_len,
  output logic [PG_W-1:0]  nxt_pg
);
  localparam int SW = (LEN_W > PG_W ? LEN_W : PG_W) + 2;

  logic [SW-1:0] span, pages, raw, fold;

  always_comb begin
    span  = SW'(frm_len) + SW'(rxr_pkg::HDR_BYTES + rxr_pkg::CRC_PAD)
          + SW'((1 << OFF_W) - 1);
    pages = span >> OFF_W;
    raw   = SW'(cur_pg) + pages;
    if (raw >= SW'(stop_pg))
      fold = raw - (SW'(stop_pg) - SW'(start_pg));
    else
      fold = raw;
    nxt_pg = fold[PG_W-1:0];
  end
endmodule

// File: rtl/rxr_ring_writer.sv
`timescale 1ns/1ps
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int PG_W      = 8,
  parameter int OFF_W     = 8,
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 1514
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PG_W-1:0]       cfg_start_pg,
  input  logic [PG_W-1:0]       cfg_stop_pg,
  input  logic [PG_W-1:0]       cfg_bnd_pg,
  input  logic                  cmd_halt,
  input  logic                  cur_ld,
  input  logic [PG_W-1:0]       cur_ld_pg,
  input  logic                  irq_clr,
  input  logic                  frm_sof,
  input  logic                  frm_valid,
  input  logic                  frm_eof,
  input  logic [7:0]            frm_data,
  output logic                  mem_we,
  output logic [PG_W+OFF_W-1:0] mem_addr,
  output logic [7:0]            mem_wdata,
  output logic [PG_W-1:0]       cur_pg,
  output logic [7:0]            rx_stat,
  output logic                  rx_irq,
  output logic                  rx_drop
);
  localparam int AW = PG_W + OFF_W;
  localparam logic [OFF_W-1:0] ZOFF = '0;

  rxr_state_e       state;
  logic [AW-1:0]    wptr;
  logic [LEN_W-1:0] len_q;
  logic [1:0]       hidx;
  logic             room_ok;
  logic [PG_W-1:0]  nxt_pg;
  logic [LEN_W-1:0] stored_len;
  logic [AW-1:0]    first_a;
  logic             sof_hit;

  rxr_space_chk #(.PG_W(PG_W), .OFF_W(OFF_W), .MAX_FRAME(MAX_FRAME)) u_space (
    .start_pg(cfg_start_pg), .stop_pg(cfg_stop_pg), .bnd_pg(cfg_bnd_pg),
    .cur_pg(cur_pg), .room_ok(room_ok)
  );

  rxr_next_page #(.PG_W(PG_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_next (
    .cur_pg(cur_pg), .start_pg(cfg_start_pg), .stop_pg(cfg_stop_pg),
    .frm_len(len_q), .nxt_pg(nxt_pg)
  );

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                         input logic [PG_W-1:0] s,
                                         input logic [PG_W-1:0] e);
    logic [AW-1:0] n;
    n = p + 1'b1;
    if (n == {e, ZOFF}) n = {s, ZOFF};
    return n;
  endfunction

  assign stored_len = len_q + LEN_W'(HDR_BYTES);
  assign first_a    = {cur_pg, ZOFF} + AW'(HDR_BYTES);
  assign sof_hit    = frm_valid && frm_sof && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wptr      <= '0;
      len_q     <= '0;
      hidx      <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cur_pg    <= '0;
      rx_stat   <= '0;
      rx_irq    <= 1'b0;
      rx_drop   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      rx_drop <= 1'b0;
      if (irq_clr) rx_irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (sof_hit) begin
            if (room_ok && !cmd_halt) begin
              mem_we    <= 1'b1;
              mem_addr  <= first_a;
              mem_wdata <= frm_data;
              wptr      <= step(first_a, cfg_start_pg, cfg_stop_pg);
              len_q     <= LEN_W'(1);
              hidx      <= '0;
              state     <= frm_eof ? ST_HDR : ST_DATA;
            end else begin
              rx_drop <= 1'b1;
              state   <= frm_eof ? ST_IDLE : ST_SKIP;
            end
          end else if (cur_ld) begin
            cur_pg <= cur_ld_pg;
          end
        end
        ST_DATA: begin
          if (frm_valid) begin
            mem_we    <= 1'b1;
            mem_addr  <= wptr;
            mem_wdata <= frm_data;
            wptr      <= step(wptr, cfg_start_pg, cfg_stop_pg);
            len_q     <= len_q + 1'b1;
            if (frm_eof) begin
              hidx  <= '0;
              state <= ST_HDR;
            end
          end
        end
        ST_SKIP: begin
          if (frm_valid && frm_eof) state <= ST_IDLE;
        end
        ST_HDR: begin
          mem_we   <= 1'b1;
          mem_addr <= {cur_pg, ZOFF} + AW'(hidx);
          case (hidx)
            2'd0:    mem_wdata <= RX_GOOD;
            2'd1:    mem_wdata <= 8'(nxt_pg);
            2'd2:    mem_wdata <= stored_len[7:0];
            default: mem_wdata <= 8'(stored_len >> 8);
          endcase
          hidx <= hidx + 1'b1;
          if (hidx == 2'd3) begin
            cur_pg  <= nxt_pg;
            rx_irq  <= 1'b1;
            rx_stat <= RX_GOOD;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13
  addr_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr >= {cfg_start_pg, ZOFF} && mem_addr < {cfg_stop_pg, ZOFF}));

  // R6
  drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rx_drop |-> !mem_we);

  // R12
  sof_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_sof) |-> (state == ST_IDLE));

  // R10
  cur_move_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_pg != $past(cur_pg) && !$past(cur_ld)) |-> (rx_irq && rx_stat == RX_GOOD));

  // R6
  drop_keeps_cur_chk: assert property (@(posedge clk) disable iff (rst)
    rx_drop |=> $stable(cur_pg));
endmodule

// File: tb/sim_rxr_ring_writer.sv
`timescale 1ns/1ps
module sim_rxr_ring_writer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg_start_pg = 8'd0, cfg_stop_pg = 8'd0, cfg_bnd_pg = 8'd0;
  logic cmd_halt = 1'b0, cur_ld = 1'b0, irq_clr = 1'b0;
  logic [7:0] cur_ld_pg = 8'd0;
  logic frm_sof = 1'b0, frm_valid = 1'b0, frm_eof = 1'b0;
  logic [7:0] frm_data = 8'd0;
  logic mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, cur_pg, rx_stat;
  logic rx_irq, rx_drop;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int drop_cnt = 0;
  logic [7:0] mem [0:4095];

  always #2 clk = ~clk;

  rxr_ring_writer u0 (
    .clk(clk), .rst(rst), .cfg_start_pg(cfg_start_pg), .cfg_stop_pg(cfg_stop_pg),
    .cfg_bnd_pg(cfg_bnd_pg), .cmd_halt(cmd_halt), .cur_ld(cur_ld), .cur_ld_pg(cur_ld_pg),
    .irq_clr(irq_clr), .frm_sof(frm_sof), .frm_valid(frm_valid), .frm_eof(frm_eof),
    .frm_data(frm_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_pg(cur_pg), .rx_stat(rx_stat), .rx_irq(rx_irq), .rx_drop(rx_drop)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (rx_drop) drop_cnt <= drop_cnt + 1;
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 7 + seed) & 255);
  endfunction

  task automatic setup(input int s, input int e, input int b, input int c);
    @(negedge clk);
    cfg_start_pg = 8'(s); cfg_stop_pg = 8'(e); cfg_bnd_pg = 8'(b);
    cur_ld = 1'b1; cur_ld_pg = 8'(c);
    @(negedge clk);
    cur_ld = 1'b0;
    chk("R11 current page load", int'(cur_pg), c);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic drive_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      frm_valid = 1'b1; frm_sof = (i == 0); frm_eof = (i == len - 1);
      frm_data = pat(i, seed);
    end
    @(negedge clk);
    frm_valid = 1'b0; frm_sof = 1'b0; frm_eof = 1'b0;
  endtask

  task automatic rx_ok(input string tag, input int len, input int seed, input int exp_next);
    int old, w0, base, ring, bad, a;
    old = int'(cur_pg); w0 = wr_cnt; base = old * 256;
    ring = (int'(cfg_stop_pg) - int'(cfg_start_pg)) * 256;
    drive_frame(len, seed);
    repeat (3) @(negedge clk);
    chk({tag, " R12 cur before 4th header write"}, int'(cur_pg), old);
    @(negedge clk);
    chk({tag, " R7 next page"}, int'(cur_pg), exp_next);
    chk({tag, " R10 irq set"}, int'(rx_irq), 1);
    chk({tag, " R10 status"}, int'(rx_stat), 1);
    repeat (2) @(negedge clk);
    chk({tag, " R12 write count"}, wr_cnt - w0, len + 4);
    chk({tag, " R8 hdr status"}, int'(mem[base]), 1);
    chk({tag, " R8 hdr next"}, int'(mem[base + 1]), exp_next);
    chk({tag, " R8 hdr len lo"}, int'(mem[base + 2]), (len + 4) & 255);
    chk({tag, " R8 hdr len hi"}, int'(mem[base + 3]), (len + 4) >> 8);
    bad = 0;
    for (int i = 0; i < len; i++) begin
      a = base + 4 + i;
      if (a >= int'(cfg_stop_pg) * 256) a = a - ring;
      if (mem[a] !== pat(i, seed)) bad++;
    end
    chk({tag, " R2 R9 data bytes mismatched"}, bad, 0);
  endtask

  task automatic rx_drop_case(input string tag, input int len);
    int w0, d0, c0, s0;
    clear_irq();
    w0 = wr_cnt; d0 = drop_cnt; c0 = int'(cur_pg); s0 = int'(rx_stat);
    drive_frame(len, 3);
    repeat (6) @(negedge clk);
    chk({tag, " R6 drop pulse"}, drop_cnt - d0, 1);
    chk({tag, " R6 no writes"}, wr_cnt - w0, 0);
    chk({tag, " R6 cur unchanged"}, int'(cur_pg), c0);
    chk({tag, " R6 irq unchanged"}, int'(rx_irq), 0);
    chk({tag, " R6 status unchanged"}, int'(rx_stat), s0);
  endtask

  task automatic t_reset();
    chk("R1 cur", int'(cur_pg), 0);
    chk("R1 irq", int'(rx_irq), 0);
    chk("R1 stat", int'(rx_stat), 0);
    chk("R1 drop", int'(rx_drop), 0);
    chk("R1 we", int'(mem_we), 0);
  endtask

  task automatic t_basic();
    setup(2, 12, 2, 2);
    rx_ok("basic", 60, 5, 3);
  endtask

  task automatic t_round();
    setup(2, 12, 2, 3);
    rx_ok("R7 exact page", 248, 11, 4);
    rx_ok("R7 one over", 249, 17, 6);
    rx_ok("R7 single byte", 1, 23, 7);
  endtask

  task automatic t_wrap();
    setup(2, 12, 8, 11);
    rx_ok("R9 wrap", 300, 9, 3);
    chk("R9 last byte before stop", int'(mem[12'hBFF]), int'(pat(251, 9)));
    chk("R9 first byte at start", int'(mem[12'h200]), int'(pat(252, 9)));
    chk("R9 final byte", int'(mem[12'h22F]), int'(pat(299, 9)));
  endtask

  task automatic t_space();
    setup(2, 12, 8, 2);
    rx_ok("R4 room 1536", 40, 1, 3);
    setup(2, 12, 7, 2);
    rx_drop_case("R4 room 1280 below", 40);
    setup(2, 12, 4, 9);
    rx_drop_case("R4 cur above bnd short", 40);
  endtask

  task automatic t_bad_ring();
    setup(5, 5, 5, 5);
    rx_drop_case("R3 stop equals start", 20);
    setup(8, 4, 4, 4);
    rx_drop_case("R3 stop below start", 20);
  endtask

  task automatic t_halt();
    setup(2, 12, 2, 2);
    @(negedge clk); cmd_halt = 1'b1;
    rx_drop_case("R5 halted", 30);
    @(negedge clk); cmd_halt = 1'b0;
    rx_ok("R5 resumed", 30, 4, 3);
  endtask

  task automatic t_irq();
    chk("R10 irq before clear", int'(rx_irq), 1);
    clear_irq();
    chk("R10 irq cleared", int'(rx_irq), 0);
    chk("R10 status kept", int'(rx_stat), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_irq();
    t_round();
    t_wrap();
    t_space();
    t_bad_ring();
    t_halt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule